// File: doc/BRIEF.md
# Console Device Register Block

This block sits at the top of a 16-bit byte-addressed space and answers every bus access whose address falls in the upper 512 bytes (0xFE00 to 0xFFFF). Memory does not answer these addresses. Inside that window it provides five word registers:

- **Keyboard status and data.** A character source drops bytes in with a one-cycle strobe. Software sees a ready flag and takes the byte. An enable bit lets a waiting byte raise an interrupt.
- **Display status and data.** Software writes a byte for a character sink and watches a ready flag until the sink has taken it through a valid/ack handshake.
- **Machine control.** Bit 15 of this word drives the clock-enable output that lets the processor keep running.

Two small state machines carry the device state:

- **Keyboard machine:** `KIN_EMPTY` and `KIN_HELD`.
  - `KIN_EMPTY` goes to `KIN_HELD` on a strobe.
  - `KIN_HELD` goes back to `KIN_EMPTY` on a bus read of the keyboard data word, unless a strobe arrives in the same cycle.
- **Display machine:** `DOUT_IDLE` and `DOUT_SEND`.
  - `DOUT_IDLE` goes to `DOUT_SEND` on a bus write to the display data word.
  - `DOUT_SEND` goes back to `DOUT_IDLE` on a cycle with `dout_ack` high.

The interrupt request carries a fixed level 4 and a fixed vector 0x80. The processor compares the level against the running level it supplies.

Top module: `console_devregs`

## Requirements
- R1: `bus_hit` is 1 exactly when `bus_addr` is 0xFE00 or above. When `bus_hit` is 0, `bus_rdata` is 0 and writes change no register.
- R2: A cycle with `kin_strobe` high stores `kin_char`. From the next cycle on:
  - the keyboard data word (0xFE02) reads that byte in bits 7:0, with 0 above it;
  - the keyboard status word (0xFE00) reads bit 15 = 1.
- R3: A cycle with `bus_rd` high at 0xFE02 clears keyboard ready (0xFE00 bit 15) at the next edge. If `kin_strobe` is high in the same cycle, ready stays 1 and the new byte is stored.
- R4: Bit 14 of 0xFE00 is the interrupt enable and is set or cleared by a bus write. Bit 15 cannot be written, and bits 13:0 always read 0.
- R5: `irq_req` is 1 exactly when all three hold: keyboard ready = 1, enable = 1, and `cur_pri` < 4. `irq_pri` is always 4 and `irq_vec` is always 0x80.
- R6: While the display is idle, 0xFE04 reads 0x8000. A write to 0xFE06 stores `bus_wdata[7:0]` and, from the next cycle on:
  - `dout_char` shows that byte;
  - `dout_valid` is 1;
  - 0xFE04 reads 0;
  - 0xFE06 reads that byte zero-extended.
- R7: `dout_valid` and `dout_char` hold until a cycle with `dout_ack` high. In the cycle after that, `dout_valid` is 0 and 0xFE04 reads 0x8000. A write to 0xFE06 while `dout_valid` is 1 is ignored.
- R8: The machine control word (0xFFFE) resets to 0x8000. All 16 bits can be written and read back, and `run_en` equals its bit 15.
- R9: Reads of any other word in the window return 0, and writes to those words change no register. Address bit 0 is ignored, so 0xFE05 reads the same as 0xFE04.
- R10: After reset:
  - 0xFE00 and 0xFE02 read 0;
  - 0xFE04 reads 0x8000;
  - `dout_valid` and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Read strobe; qualifies read side effects only |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| bus_hit | output | 1 | Address lies in the device window |
| kin_strobe | input | 1 | A new input character is present |
| kin_char | input | 8 | Input character |
| dout_valid | output | 1 | Output character waiting for the sink |
| dout_char | output | 8 | Output character |
| dout_ack | input | 1 | Sink takes the output character |
| run_en | output | 1 | Clock enable for instruction processing |
| cur_pri | input | 3 | Priority level of the running program |
| irq_req | output | 1 | Keyboard interrupt request |
| irq_pri | output | 3 | Priority level of the request (4) |
| irq_vec | output | 8 | Interrupt vector (0x80) |

## Verification
The bench targets a read of the keyboard data that coincides with a new strobe. A design that let the read win would lose the new byte's ready flag.

It sweeps all eight running levels against every combination of ready and enable. An off-by-one comparison at level 4 would raise a request that must not be raised, or drop one that should be.

It writes to the display while a character is still unacknowledged. A design without the busy guard would overwrite the byte in flight.

It sweeps all 256 words of the window, and it writes to addresses that share low bits with real registers but lie outside the window. Loose decoding shows up either as stray read data or as a machine control word that changes when it should not.

// File: rtl/console_devregs_pkg.sv
package console_devregs_pkg;

    typedef enum logic {
        KIN_EMPTY,
        KIN_HELD
    } kin_state_t;

    typedef enum logic {
        DOUT_IDLE,
        DOUT_SEND
    } dout_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA,
        SEL_CTRL
    } reg_sel_t;

    // Word index within the device window (byte address bits above bit 0).
    // The control word is the top word of the window.
    localparam int IDX_KSTAT = 0;
    localparam int IDX_KDATA = 1;
    localparam int IDX_DSTAT = 2;
    localparam int IDX_DDATA = 3;

endpackage

// File: rtl/cdr_addr_decode.sv
module cdr_addr_decode
    import console_devregs_pkg::*;
#(
    parameter int AW         = 16,
    parameter int REGION_LSB = 9
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output reg_sel_t      sel
);
    localparam int IDX_W = REGION_LSB - 1;

    logic [IDX_W-1:0] idx;
    logic             unused_lsb;

    assign hit        = &addr[AW-1:REGION_LSB];
    assign idx        = addr[REGION_LSB-1:1];
    assign unused_lsb = addr[0];

    always_comb begin
        sel = SEL_NONE;
        if (hit) begin
            if (idx == IDX_W'(IDX_KSTAT)) begin
                sel = SEL_KSTAT;
            end else if (idx == IDX_W'(IDX_KDATA)) begin
                sel = SEL_KDATA;
            end else if (idx == IDX_W'(IDX_DSTAT)) begin
                sel = SEL_DSTAT;
            end else if (idx == IDX_W'(IDX_DDATA)) begin
                sel = SEL_DDATA;
            end else if (idx == {IDX_W{1'b1}}) begin
                sel = SEL_CTRL;
            end
        end
    end
endmodule

// File: rtl/cdr_kin_port.sv
module cdr_kin_port
    import console_devregs_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_strobe,
    input  logic [CW-1:0] in_char,
    input  logic          consume,
    input  logic          ie_we,
    input  logic          ie_d,
    output logic          ready,
    output logic          ie,
    output logic [CW-1:0] held_char
);
    kin_state_t st_q, st_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KIN_EMPTY;
        else        st_q <= st_d;
    end

    // Transitions: a strobe always wins over a consuming read
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            KIN_EMPTY: if (in_strobe)             st_d = KIN_HELD;
            KIN_HELD:  if (consume && !in_strobe) st_d = KIN_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        ready = (st_q == KIN_HELD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_char <= '0;
            ie        <= 1'b0;
        end else begin
            if (in_strobe) held_char <= in_char;
            if (ie_we)     ie        <= ie_d;
        end
    end
endmodule

// File: rtl/cdr_dout_port.sv
module cdr_dout_port
    import console_devregs_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send_we,
    input  logic [CW-1:0] send_char,
    input  logic          ack,
    output logic          ready,
    output logic          valid,
    output logic [CW-1:0] out_char
);
    dout_state_t st_q, st_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DOUT_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DOUT_IDLE: if (send_we) st_d = DOUT_SEND;
            DOUT_SEND: if (ack)     st_d = DOUT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready = (st_q == DOUT_IDLE);
        valid = (st_q == DOUT_SEND);
    end

    // The character is only captured when the sink is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_char <= '0;
        end else if (send_we && st_q == DOUT_IDLE) begin
            out_char <= send_char;
        end
    end
endmodule

// File: rtl/console_devregs.sv
module console_devregs
    import console_devregs_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter int          CW         = 8,
    parameter int          PRI_W      = 3,
    parameter int          VEC_W      = 8,
    parameter int          REGION_LSB = 9,
    parameter int          IRQ_LEVEL  = 4,
    parameter logic [7:0]  IRQ_VECTOR = 8'h80,
    parameter logic [15:0] CTRL_RESET = 16'h8000,
    parameter int          READY_BIT  = 15,
    parameter int          IE_BIT     = 14,
    parameter int          RUN_BIT    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_hit,
    input  logic             kin_strobe,
    input  logic [CW-1:0]    kin_char,
    output logic             dout_valid,
    output logic [CW-1:0]    dout_char,
    input  logic             dout_ack,
    output logic             run_en,
    input  logic [PRI_W-1:0] cur_pri,
    output logic             irq_req,
    output logic [PRI_W-1:0] irq_pri,
    output logic [VEC_W-1:0] irq_vec
);
    reg_sel_t        sel;
    logic            kb_ready;
    logic            kb_ie;
    logic [CW-1:0]   kb_char;
    logic            dsp_ready;
    logic [DW-1:0]   ctrl_q;

    logic            wr_kstat;
    logic            rd_kdata;
    logic            wr_ddata;
    logic            wr_ctrl;

    cdr_addr_decode #(
        .AW         (AW),
        .REGION_LSB (REGION_LSB)
    ) u_decode (
        .addr (bus_addr),
        .hit  (bus_hit),
        .sel  (sel)
    );

    assign wr_kstat = bus_wr && (sel == SEL_KSTAT);
    assign rd_kdata = bus_rd && (sel == SEL_KDATA);
    assign wr_ddata = bus_wr && (sel == SEL_DDATA);
    assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);

    cdr_kin_port #(
        .CW (CW)
    ) u_kin (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_strobe (kin_strobe),
        .in_char   (kin_char),
        .consume   (rd_kdata),
        .ie_we     (wr_kstat),
        .ie_d      (bus_wdata[IE_BIT]),
        .ready     (kb_ready),
        .ie        (kb_ie),
        .held_char (kb_char)
    );

    cdr_dout_port #(
        .CW (CW)
    ) u_dout (
        .clk       (clk),
        .rst_n     (rst_n),
        .send_we   (wr_ddata),
        .send_char (bus_wdata[CW-1:0]),
        .ack       (dout_ack),
        .ready     (dsp_ready),
        .valid     (dout_valid),
        .out_char  (dout_char)
    );

    // Machine control word
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= DW'(CTRL_RESET);
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    assign run_en = ctrl_q[RUN_BIT];

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_KSTAT: begin
                bus_rdata[READY_BIT] = kb_ready;
                bus_rdata[IE_BIT]    = kb_ie;
            end
            SEL_KDATA: bus_rdata[CW-1:0]     = kb_char;
            SEL_DSTAT: bus_rdata[READY_BIT]  = dsp_ready;
            SEL_DDATA: bus_rdata[CW-1:0]     = dout_char;
            SEL_CTRL:  bus_rdata             = ctrl_q;
            default:   bus_rdata             = '0;
        endcase
    end

    // Keyboard interrupt request
    assign irq_req = kb_ready && kb_ie && (cur_pri < PRI_W'(IRQ_LEVEL));
    assign irq_pri = PRI_W'(IRQ_LEVEL);
    assign irq_vec = VEC_W'(IRQ_VECTOR);
endmodule

// File: rtl/console_devregs_chk.sv
module console_devregs_chk #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_hit,
    input logic          kin_strobe,
    input logic [CW-1:0] kin_char,
    input logic          dout_valid,
    input logic [CW-1:0] dout_char,
    input logic          dout_ack,
    input logic          run_en,
    input logic          irq_req,
    input logic          kb_ready,
    input logic [CW-1:0] kb_char
);
    logic kdata_read;
    logic ddata_write;

    assign kdata_read  = bus_rd && bus_hit && (bus_addr[8:1] == 8'd1);
    assign ddata_write = bus_wr && bus_hit && (bus_addr[8:1] == 8'd3);

    // R2
    a_r2_strobe_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        kin_strobe |=> (kb_ready && kb_char == $past(kin_char)));

    // R3
    a_r3_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (kdata_read && !kin_strobe) |=> !kb_ready);

    // R6
    a_r6_write_starts_send: assert property (@(posedge clk) disable iff (!rst_n)
        (ddata_write && !dout_valid) |=> (dout_valid && dout_char == $past(bus_wdata[CW-1:0])));

    // R7
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ack) |=> (dout_valid && $stable(dout_char)));

    // R7
    a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && dout_ack) |=> !dout_valid);

    // R1
    a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |-> (bus_rdata == '0));

    // R5
    a_r5_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> kb_ready);

    // R8
    a_r8_run_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_en) |-> $past(bus_wr && bus_hit));
endmodule

bind console_devregs console_devregs_chk #(
    .AW (AW),
    .DW (DW),
    .CW (CW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_hit    (bus_hit),
    .kin_strobe (kin_strobe),
    .kin_char   (kin_char),
    .dout_valid (dout_valid),
    .dout_char  (dout_char),
    .dout_ack   (dout_ack),
    .run_en     (run_en),
    .irq_req    (irq_req),
    .kb_ready   (kb_ready),
    .kb_char    (kb_char)
);

// File: tb/test_console_devregs.sv
module test_console_devregs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic        kin_strobe;
    logic [7:0]  kin_char;
    logic        dout_valid;
    logic [7:0]  dout_char;
    logic        dout_ack;
    logic        run_en;
    logic [2:0]  cur_pri;
    logic        irq_req;
    logic [2:0]  irq_pri;
    logic [7:0]  irq_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    console_devregs i_console_devregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_hit    (bus_hit),
        .kin_strobe (kin_strobe),
        .kin_char   (kin_char),
        .dout_valid (dout_valid),
        .dout_char  (dout_char),
        .dout_ack   (dout_ack),
        .run_en     (run_en),
        .cur_pri    (cur_pri),
        .irq_req    (irq_req),
        .irq_pri    (irq_pri),
        .irq_vec    (irq_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic peek(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        step();
        bus_rd   = 1'b0;
    endtask

    task automatic put_key(input logic [7:0] c);
        kin_char   = c;
        kin_strobe = 1'b1;
        step();
        kin_strobe = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  last_key;
        logic [7:0]  last_out;
        logic [15:0] ctrl_exp;

        rst_n = 1'b0;
        bus_addr = 16'h0000;
        bus_wr = 0;
        bus_rd = 0;
        bus_wdata = 0;
        kin_strobe = 0;
        kin_char = 0;
        dout_ack = 0;
        cur_pri = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R10 / R8: reset state
        peek(16'hFE00, d); chk("R10 kstat", d, 16'h0000);
        peek(16'hFE02, d); chk("R10 kdata", d, 16'h0000);
        peek(16'hFE04, d); chk("R10 dstat", d, 16'h8000);
        peek(16'hFFFE, d); chk("R8 ctrl reset", d, 16'h8000);
        chk("R8 run_en reset", run_en, 1);
        chk("R10 dout_valid", dout_valid, 0);
        chk("R10 irq_req", irq_req, 0);

        // R2 / R3: keyboard sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] c;
            c = 8'(i * 17 + 3);
            put_key(c);
            peek(16'hFE00, d); chk("R2 ready set", d[15], 1);
            peek(16'hFE02, d); chk("R2 kdata", d, {8'h00, c});
            bus_read(16'hFE02, d); chk("R3 read data", d, {8'h00, c});
            peek(16'hFE00, d); chk("R3 ready cleared", d[15], 0);
        end

        // R3: strobe coinciding with a consuming read
        put_key(8'h41);
        kin_char   = 8'h42;
        kin_strobe = 1'b1;
        bus_read(16'hFE02, d);
        kin_strobe = 1'b0;
        chk("R3 read before strobe", d, 16'h0041);
        peek(16'hFE00, d); chk("R3 strobe wins ready", d[15], 1);
        peek(16'hFE02, d); chk("R3 strobe wins data", d, 16'h0042);
        last_key = 8'h42;

        // R4: writes to the keyboard status word
        bus_read(16'hFE02, d);
        bus_write(16'hFE00, 16'hFFFF);
        peek(16'hFE00, d); chk("R4 only ie written", d, 16'h4000);
        bus_write(16'hFE00, 16'h0000);
        peek(16'hFE00, d); chk("R4 ie cleared", d, 16'h0000);

        // R5: interrupt gating sweep
        for (int ie = 0; ie < 2; ie++) begin
            for (int rdy = 0; rdy < 2; rdy++) begin
                bus_write(16'hFE00, ie != 0 ? 16'h4000 : 16'h0000);
                if (rdy != 0) put_key(last_key);
                else          bus_read(16'hFE02, d);
                for (int p = 0; p < 8; p++) begin
                    cur_pri = 3'(p);
                    #1;
                    chk("R5 irq_req", irq_req, (ie != 0 && rdy != 0 && p < 4) ? 1 : 0);
                    chk("R5 irq_pri", irq_pri, 3'd4);
                    chk("R5 irq_vec", irq_vec, 8'h80);
                end
            end
        end
        cur_pri = 0;
        bus_write(16'hFE00, 16'h0000);
        bus_read(16'hFE02, d);

        // R6 / R7: display sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c;
            c = 8'(i * 29 + 7);
            peek(16'hFE04, d); chk("R6 idle ready", d, 16'h8000);
            bus_write(16'hFE06, {8'hA5, c});
            chk("R6 valid", dout_valid, 1);
            chk("R6 char", dout_char, c);
            peek(16'hFE04, d); chk("R6 busy status", d, 16'h0000);
            peek(16'hFE06, d); chk("R6 data readback", d, {8'h00, c});
            for (int h = 0; h < 3; h++) begin
                step();
                chk("R7 hold valid", dout_valid, 1);
                chk("R7 hold char", dout_char, c);
            end
            bus_write(16'hFE06, {8'h00, ~c});
            chk("R7 busy write ignored", dout_char, c);
            dout_ack = 1'b1;
            step();
            dout_ack = 1'b0;
            chk("R7 released", dout_valid, 0);
            peek(16'hFE04, d); chk("R7 ready again", d, 16'h8000);
            last_out = c;
        end

        // R8: machine control
        bus_write(16'hFFFE, 16'h1234);
        chk("R8 run_en low", run_en, 0);
        peek(16'hFFFE, d); chk("R8 readback", d, 16'h1234);
        bus_write(16'hFFFE, 16'h8001);
        chk("R8 run_en high", run_en, 1);
        ctrl_exp = 16'h8001;

        // R1: outside the window
        bus_write(16'h7FFE, 16'h0000);
        bus_write(16'hFDFE, 16'h0000);
        chk("R1 outside write ignored", run_en, 1);
        peek(16'hFDFE, d); chk("R1 outside rdata", d, 0);
        chk("R1 outside hit", bus_hit, 0);
        peek(16'h0000, d); chk("R1 low hit", bus_hit, 0);
        peek(16'hFE00, d); chk("R1 window edge hit", bus_hit, 1);

        // R9: unimplemented words and bit 0
        bus_write(16'hFE08, 16'hFFFF);
        bus_write(16'hFFFC, 16'h0000);
        peek(16'hFE05, d); chk("R9 odd address", d, 16'h8000);
        put_key(8'h5A);
        last_key = 8'h5A;
        for (int w = 0; w < 256; w++) begin
            logic [15:0] a;
            logic [15:0] e;
            a = 16'hFE00 + 16'(w * 2);
            case (w)
                0:       e = 16'h8000;
                1:       e = {8'h00, last_key};
                2:       e = 16'h8000;
                3:       e = {8'h00, last_out};
                255:     e = ctrl_exp;
                default: e = 16'h0000;
            endcase
            peek(a, d);
            chk("R9 window sweep", d, e);
            chk("R1 window hit", bus_hit, 1);
        end

        step();
        finish_up();
    end
endmodule